// File: doc/BRIEF.md
# Parallel Magnitude Argmax Atom Selector

This block finds the dictionary column whose correlation with the current residual has the greatest absolute value. A wide vector datapath delivers `LANES` single-precision correlation words per beat. A long correlation vector is folded into several consecutive beats, and the final beat is flagged. The block compares all lanes of a beat in a pipelined binary tree. It keeps a running best across the beats of one search. When the flagged beat reaches the end of the pipeline, the block emits the winning column index for one cycle.

Each emitted index is also appended to an active-set register file of `ACT_DEPTH` entries. A combinational read port lets the rest of the engine look up any stored slot. The set is emptied by a clear input. An append that finds the set full is dropped, and a sticky overflow flag is raised instead.

Magnitude ranking uses the sign-stripped IEEE bit pattern. For non-NaN values, comparing bits [30:0] as an unsigned integer orders magnitudes exactly, so no floating-point unit is needed.

Top module: `argmax_selector`

## Requirements
- R1: The column index of lane `l` on beat `b` of a search is `b*LANES + l`, with the beat count restarting at 0 after a flagged beat. The result is the index whose word has the largest bits [30:0], compared as an unsigned integer. Bit 31 (sign) is ignored.
- R2: When lanes of one beat tie on magnitude, the lowest lane wins.
- R3: When a later beat ties with the best so far, the earlier beat's index is kept.
- R4: On a beat with `in_last` high, only lanes `0 .. in_count-1` take part, where `in_count` is 1 to `LANES`. Beats without `in_last` use every lane.
- R5: `res_valid` is high for exactly one cycle, `log2(LANES)+2` cycles after a beat with `in_valid` and `in_last` high is accepted. With the default of 128 lanes this is 9 cycles. Beats without `in_last` never produce a result. Beats may be presented back to back or with gaps.
- R6: A flagged beat ends its search. The next beat starts a fresh search that is unaffected by earlier values.
- R7: On the edge that raises `res_valid`, the index is written to slot `act_count` and `act_count` increases by one.
- R8: When `act_count` equals `ACT_DEPTH`, an append is refused. `act_count` stays at `ACT_DEPTH` and `act_ovf` sets and stays set.
- R9: A cycle with `act_clear` high makes `act_count` 0 and `act_ovf` 0 from the next cycle on. A clear takes precedence over an append on the same edge, and that append is lost.
- R10: After reset, `res_valid`, `act_count` and `act_ovf` are 0.
- R11: `rd_data` shows, without delay, the index stored in slot `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A correlation beat is present |
| in_last | input | 1 | This beat ends the current search |
| in_count | input | $clog2(LANES+1) | Number of valid lanes on a flagged beat |
| in_corr | input | LANES*32 | Lane `l` in bits `[32*l+31 : 32*l]`, IEEE single precision |
| act_clear | input | 1 | Empty the active set |
| res_valid | output | 1 | One-cycle strobe for a finished search |
| res_index | output | $clog2(MAX_BEATS)+$clog2(LANES) | Winning column index |
| act_count | output | $clog2(ACT_DEPTH+1) | Number of stored indices |
| act_ovf | output | 1 | Sticky flag for a refused append |
| rd_addr | input | $clog2(ACT_DEPTH) | Active-set read slot |
| rd_data | output | $clog2(MAX_BEATS)+$clog2(LANES) | Index stored in the read slot |

## Verification
The result strobe and its index are due `log2(LANES)+2` cycles after the flagged beat is taken. The active-set count and overflow flag change on that same edge. A clear shows one cycle after it is driven.

The bench reference model stamps every flagged beat with the cycle it is due and keeps those stamps in a queue. Each clock, it compares the strobe, index, count and flag against whatever falls due in that cycle, so a result one cycle early or late is reported. Read-port contents are sampled shortly after the address changes, with no clock edge in between.

// File: rtl/argmax_selector.sv
module argmax_selector #(
  parameter int LANES     = 128,
  parameter int MAX_BEATS = 16,
  parameter int ACT_DEPTH = 320,
  localparam int LW  = $clog2(LANES),
  localparam int BW  = $clog2(MAX_BEATS),
  localparam int IW  = LW + BW,
  localparam int CW  = $clog2(LANES + 1),
  localparam int AW  = $clog2(ACT_DEPTH),
  localparam int ACW = $clog2(ACT_DEPTH + 1),
  localparam int LEVELS = LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [CW-1:0]     in_count,
  input  logic [LANES*32-1:0] in_corr,
  input  logic              act_clear,
  output logic              res_valid,
  output logic [IW-1:0]     res_index,
  output logic [ACW-1:0]    act_count,
  output logic              act_ovf,
  input  logic [AW-1:0]     rd_addr,
  output logic [IW-1:0]     rd_data
);

  // heap-ordered comparison tree: node n has children 2n and 2n+1, leaves at LANES..2*LANES-1
  logic [30:0]   hmag  [1:2*LANES-1];
  logic          hv    [1:2*LANES-1];
  logic [LW-1:0] hlane [1:2*LANES-1];
  logic          pick_r [1:LANES-1];
  logic [LANES-1:0] unused_sign;

  always_comb begin
    for (int i = 0; i < LANES; i++) unused_sign[i] = in_corr[32*i+31];
    for (int n = 1; n < LANES; n++)
      pick_r[n] = hv[2*n+1] && (!hv[2*n] || hmag[2*n+1] > hmag[2*n]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      hmag[LANES+i]  <= in_corr[32*i +: 31];
      hlane[LANES+i] <= LW'(i);
    end
    for (int n = 1; n < LANES; n++) begin
      hmag[n]  <= pick_r[n] ? hmag[2*n+1]  : hmag[2*n];
      hlane[n] <= pick_r[n] ? hlane[2*n+1] : hlane[2*n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n < 2*LANES; n++) hv[n] <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++)
        hv[LANES+i] <= in_valid && (!in_last || CW'(i) < in_count);
      for (int n = 1; n < LANES; n++)
        hv[n] <= hv[2*n] || hv[2*n+1];
    end
  end

  // beat tags travel alongside the tree levels
  logic          tv [0:LEVELS];
  logic          tl [0:LEVELS];
  logic [BW-1:0] tb [0:LEVELS];
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      for (int k = 0; k <= LEVELS; k++) begin
        tv[k] <= 1'b0;
        tl[k] <= 1'b0;
        tb[k] <= '0;
      end
    end else begin
      if (in_valid) beat_q <= in_last ? '0 : beat_q + 1'b1;
      tv[0] <= in_valid;
      tl[0] <= in_valid && in_last;
      tb[0] <= beat_q;
      for (int k = 1; k <= LEVELS; k++) begin
        tv[k] <= tv[k-1];
        tl[k] <= tl[k-1];
        tb[k] <= tb[k-1];
      end
    end
  end

  // cross-beat running maximum; earlier beat keeps ties
  logic          run_have;
  logic [30:0]   run_mag;
  logic [IW-1:0] run_idx;

  wire [IW-1:0] root_idx  = {tb[LEVELS], hlane[1]};
  wire          take_root = hv[1] && (!run_have || hmag[1] > run_mag);
  wire [IW-1:0] cand_idx  = take_root ? root_idx : run_idx;
  wire [30:0]   cand_mag  = take_root ? hmag[1] : run_mag;
  wire          emit      = tv[LEVELS] && tl[LEVELS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_have  <= 1'b0;
      run_mag   <= '0;
      run_idx   <= '0;
      res_valid <= 1'b0;
      res_index <= '0;
    end else begin
      res_valid <= emit;
      if (emit) begin
        res_index <= cand_idx;
        run_have  <= 1'b0;
      end else if (tv[LEVELS]) begin
        run_have <= run_have || hv[1];
        run_mag  <= cand_mag;
        run_idx  <= cand_idx;
      end
    end
  end

  // active-set register file
  logic [IW-1:0] act_mem [ACT_DEPTH];
  wire room = act_count < ACW'(ACT_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_count <= '0;
      act_ovf   <= 1'b0;
    end else if (act_clear) begin
      act_count <= '0;
      act_ovf   <= 1'b0;
    end else if (emit) begin
      if (room) act_count <= act_count + 1'b1;
      else      act_ovf   <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (!act_clear && emit && room) act_mem[AW'(act_count)] <= cand_idx;

  assign rd_data = (int'(rd_addr) < ACT_DEPTH) ? act_mem[rd_addr] : '0;

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_count <= ACW'(ACT_DEPTH));

  // R5
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last, LEVELS + 2));

  // R7
  append_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(act_clear) && $past(act_count) < ACW'(ACT_DEPTH))
      |-> act_count == $past(act_count) + 1'b1);

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_ovf) |-> res_valid && $past(act_count) == ACW'(ACT_DEPTH));

  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_clear) |-> act_count == '0 && !act_ovf);

endmodule

// File: tb/sim_argmax_selector.sv
`timescale 1ns/1ps
module sim_argmax_selector;
  localparam int LANES = 128;
  localparam int MAX_BEATS = 16;
  localparam int DEPTH = 320;
  localparam int LAT = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_last, act_clear;
  logic [7:0] in_count;
  logic [LANES*32-1:0] in_corr;
  logic res_valid, act_ovf;
  logic [10:0] res_index, rd_data;
  logic [8:0] act_count, rd_addr;

  argmax_selector #(.LANES(LANES), .MAX_BEATS(MAX_BEATS), .ACT_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_count(in_count), .in_corr(in_corr), .act_clear(act_clear),
    .res_valid(res_valid), .res_index(res_index), .act_count(act_count),
    .act_ovf(act_ovf), .rd_addr(rd_addr), .rd_data(rd_data));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] vals [LANES];
  int due_q[$], idx_q[$];
  string tag_q[$];
  int exp_list[$];
  int exp_cnt = 0;
  int exp_ovf = 0;
  int clear_due = -1;
  bit m_have = 0;
  int m_mag = 0, m_idx = 0, m_beat = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, cleared;
      ev = due_q.size() > 0 && due_q[0] == cyc;
      cleared = (cyc == clear_due);
      if (cleared) begin
        exp_list.delete();
        exp_cnt = 0;
        exp_ovf = 0;
      end
      chk("R5 res_valid strobe", int'(res_valid), int'(ev));
      if (ev) begin
        int ix;
        string t;
        ix = idx_q.pop_front();
        t = tag_q.pop_front();
        void'(due_q.pop_front());
        chk(t, int'(res_index), ix);
        if (!cleared) begin
          if (exp_cnt < DEPTH) begin
            exp_list.push_back(ix);
            exp_cnt++;
          end else exp_ovf = 1;
        end
      end
      chk("R7 act_count", int'(act_count), exp_cnt);
      chk("R8 act_ovf", int'(act_ovf), exp_ovf);
    end
  end

  function automatic logic [31:0] small_val();
    logic [31:0] w;
    w = $urandom;
    w[30] = 1'b0;
    return w;
  endfunction

  task automatic fill_small();
    for (int i = 0; i < LANES; i++) vals[i] = small_val();
  endtask

  task automatic send(bit last, int cnt, string tag);
    int lim;
    @(negedge clk);
    in_valid = 1'b1;
    in_last = last;
    in_count = 8'(cnt);
    for (int i = 0; i < LANES; i++) in_corr[32*i +: 32] = vals[i];
    lim = last ? cnt : LANES;
    for (int i = 0; i < lim; i++) begin
      int mg;
      mg = int'(vals[i][30:0]);
      if (!m_have || mg > m_mag) begin
        m_have = 1;
        m_mag = mg;
        m_idx = m_beat * LANES + i;
      end
    end
    if (last) begin
      due_q.push_back(cyc + LAT);
      idx_q.push_back(m_idx);
      tag_q.push_back(tag);
      m_have = 0;
      m_beat = 0;
    end else m_beat++;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
    end
  endtask

  task automatic clear_now();
    act_clear = 1'b1;
    clear_due = cyc + 1;
    @(negedge clk);
    act_clear = 1'b0;
  endtask

  task automatic readback(string tag);
    for (int i = 0; i < exp_list.size(); i++) begin
      @(negedge clk);
      rd_addr = 9'(i);
      #1;
      chk(tag, int'(rd_data), exp_list[i]);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_count = '0;
    in_corr = '0; act_clear = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset res_valid", int'(res_valid), 0);
    chk("R10 reset act_count", int'(act_count), 0);
    chk("R10 reset act_ovf", int'(act_ovf), 0);
    rst_n = 1'b1;
    idle(2);

    // R1: three folded beats, random magnitudes
    fill_small(); send(0, LANES, "");
    fill_small(); send(0, LANES, "");
    fill_small(); send(1, LANES, "R1 three-beat argmax");
    idle(3);

    // R1: a negative word with the largest magnitude wins
    fill_small(); send(0, LANES, "");
    fill_small(); vals[77] = 32'hFF00_0000; vals[12] = 32'h7E00_0000;
    send(1, LANES, "R1 sign ignored");
    idle(1);

    // R2: tie inside a beat
    fill_small(); vals[90] = 32'h7F00_0000; vals[5] = 32'hFF00_0000;
    send(1, LANES, "R2 lowest lane on tie");
    idle(2);

    // R3: tie across beats
    fill_small(); vals[100] = 32'h7F00_0000; send(0, LANES, "");
    fill_small(); vals[2] = 32'hFF00_0000; send(1, LANES, "R3 earlier beat on tie");
    idle(4);

    // R4: masked lanes on the flagged beat
    fill_small(); send(0, LANES, "");
    fill_small();
    for (int i = 20; i < LANES; i++) vals[i] = 32'h7F7F_FFFF;
    vals[7] = 32'h4000_0000;
    send(1, 20, "R4 masked lanes ignored");
    fill_small();
    for (int i = 1; i < LANES; i++) vals[i] = 32'h7F7F_FFFF;
    send(1, 1, "R4 single valid lane");
    idle(3);

    // R6: back-to-back independent searches
    for (int s = 0; s < 6; s++) begin
      fill_small();
      vals[(s * 37) % LANES] = 32'h7000_0000 - 32'(s);
      send(1, LANES, "R6 fresh search per flag");
    end
    idle(2);

    // R1: longest folded search, winner at the top column
    for (int b = 0; b < MAX_BEATS; b++) begin
      fill_small();
      if (b == MAX_BEATS - 1) vals[LANES-1] = 32'h7F00_0000;
      send(b == MAX_BEATS - 1, LANES, "R1 highest column index");
    end
    idle(LAT + 2);

    readback("R11 active-set slot");

    // R9: clear on the same edge as an append
    fill_small(); send(1, LANES, "R9 result beside clear");
    idle(8);
    clear_now();
    idle(LAT + 2);

    // R8: fill past capacity
    for (int s = 0; s < DEPTH + 3; s++) begin
      fill_small();
      send(1, LANES, "R8 append near full");
    end
    idle(LAT + 2);
    readback("R11 full active set");
    clear_now();
    idle(3);
    finish_run();
  end
endmodule